// File: doc/BRIEF.md
# Prioritized UART Interrupt Status Register

This block collects the interrupt-causing conditions of one UART channel and turns them into a single encoded status byte and an interrupt request line. Seven conditions feed it: a receiver line-status fault, receive data ready, receive timeout, transmitter holding register empty, a modem-line change, an Xoff or special-character match, and a change on the flow-control lines. Each arrives as a one-cycle pulse or, for receive data ready, as a level. The block ranks them and shows only the most urgent one at a time.

A host reads the status byte by pulsing `rd_strobe` for one cycle. The byte on `status` in that cycle is the value read. There is no back-pressure: a read always completes in the cycle it is issued. The read retires only the source it reported, so lower-ranked sources come up on later reads. The two sources tied to flow control are masked when the extended-features input is low. The Xoff indication cannot be cleared by a read; only an Xon input clears it.

Top module: `uart_irq_status`

## Requirements
- R1: After reset, `status` is 8'h01 and `irq` is 0.
- R2: When several sources are pending, `status` reports one of them in this order of precedence, highest first: line fault, receive data ready, receive timeout, transmit holding empty, modem change, Xoff match, flow-line change.
- R3: `status[5:0]` holds the reported source: line fault 6'b000110, receive data 6'b000100, receive timeout 6'b001100, transmit holding empty 6'b000010, modem change 6'b000000, Xoff match 6'b010000, flow-line change 6'b100000. With nothing pending it is 6'b000001.
- R4: `status[0]` is 0 exactly when a source is pending, and `irq` is always its inverse.
- R5: `status[7:6]` is 2'b11 while `fifo_en` is 1 and 2'b00 while it is 0.
- R6: A cycle with `rd_strobe` high clears only the source shown on `status` in that cycle. Any lower-ranked pending source is then reported.
- R7: The Xoff and flow-line sources are neither latched nor reported while `ext_en` is 0.
- R8: Once set, the Xoff source stays pending through any number of reads until an `ev_xon` pulse arrives. An `ev_xoff` in the same cycle as `ev_xon` wins.
- R9: Receive data ready follows the `rx_avail` level. A read that reports it drops it for exactly one cycle, and it returns if `rx_avail` is still 1.
- R10: A pulse source event that arrives in the same cycle as a read that clears that source leaves the source pending.
- R11: `status` and `irq` reflect a source event from the clock edge that samples it, which is the cycle after the pulse is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFOs enabled; sets status bits 7:6 |
| ext_en | input | 1 | Enables the Xoff and flow-line sources |
| ev_line | input | 1 | Pulse: receiver line-status fault |
| rx_avail | input | 1 | Level: receive data ready condition |
| ev_rx_tmo | input | 1 | Pulse: receive timeout |
| ev_thr_empty | input | 1 | Pulse: transmit holding register emptied |
| ev_modem | input | 1 | Pulse: modem line changed |
| ev_xoff | input | 1 | Pulse: Xoff or special character matched |
| ev_xon | input | 1 | Pulse: Xon received; releases the Xoff source |
| ev_flow | input | 1 | Pulse: flow-control line changed state |
| rd_strobe | input | 1 | Host read of the status byte, one cycle |
| status | output | 8 | Encoded status byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that every `ev_*` input is a single-cycle pulse that is low throughout reset. They also assume that `rd_strobe` is only meaningful out of reset, so their clocked checks are disabled while `rst_n` is low. The random stimulus drives each event with low probability from a fixed seed, and it drives inputs only on the falling edge. The same-cycle collisions of events with reads and of Xoff with Xon still come up often. The directed part places those collisions deliberately, and it toggles `ext_en` and `fifo_en` between event bursts.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NSRC   = 7;
  localparam int IDX_W  = $clog2(NSRC + 1);
  localparam int CODE_W = 6;
  localparam int STAT_W = 8;

  // index order is the precedence order, 0 = most urgent
  localparam int S_LINE = 0;
  localparam int S_RXD  = 1;
  localparam int S_RXTO = 2;
  localparam int S_THR  = 3;
  localparam int S_MDM  = 4;
  localparam int S_XOFF = 5;
  localparam int S_FLOW = 6;

  // kind of storage each source uses
  typedef enum logic [1:0] {
    K_STICKY = 2'd0,   // pulse set, read clears
    K_LEVEL  = 2'd1,   // follows a level, read drops it one cycle
    K_HOLD   = 2'd2    // pulse set, released by a separate input
  } cell_kind_e;

  localparam logic [CODE_W-1:0] CODE_IDLE = 6'b000001;

  function automatic logic [CODE_W-1:0] src_code(input int idx);
    logic [CODE_W-1:0] c;
    case (idx)
      S_LINE:  c = 6'b000110;
      S_RXD:   c = 6'b000100;
      S_RXTO:  c = 6'b001100;
      S_THR:   c = 6'b000010;
      S_MDM:   c = 6'b000000;
      S_XOFF:  c = 6'b010000;
      S_FLOW:  c = 6'b100000;
      default: c = CODE_IDLE;
    endcase
    return c;
  endfunction

  function automatic cell_kind_e src_kind(input int idx);
    cell_kind_e k;
    case (idx)
      S_RXD:   k = K_LEVEL;
      S_XOFF:  k = K_HOLD;
      default: k = K_STICKY;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import uart_irq_pkg::*;
#(
  parameter cell_kind_e KIND = K_STICKY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,     // pulse, or level for K_LEVEL
  input  logic rel_i,     // release, used by K_HOLD only
  input  logic rd_clr_i,  // read retired this source
  output logic pend_o
);

  logic pend_q;
  logic pend_d;

  generate
    if (KIND == K_LEVEL) begin : g_level
      always_comb pend_d = set_i & ~rd_clr_i;
    end else if (KIND == K_HOLD) begin : g_hold
      always_comb pend_d = set_i | (pend_q & ~rel_i);
    end else begin : g_sticky
      always_comb pend_d = set_i | (pend_q & ~rd_clr_i);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  generate
    if (KIND == K_STICKY) begin : g_chk_sticky
      // R10: a set pulse is never lost, even when a read clears the same cycle
      a_r10_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o);
      // R6: a pending source with no read stays pending
      a_r6_hold_until_read : assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !rd_clr_i) |=> pend_o);
    end else if (KIND == K_HOLD) begin : g_chk_hold
      // R8: only the release input takes the flag down
      a_r8_xoff_sticky : assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !rel_i) |=> pend_o);
      a_r8_xoff_release : assert property (@(posedge clk) disable iff (!rst_n)
        (rel_i && !set_i) |=> !pend_o);
    end else begin : g_chk_level
      // R9: a retiring read drops the level source for one cycle
      a_r9_level_drop : assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr_i |=> !pend_o);
      a_r9_level_follow : assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !rd_clr_i) |=> pend_o);
    end
  endgenerate

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import uart_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]      req_i,
  output logic [N-1:0]      gnt_o,
  output logic              any_o,
  output logic [CODE_W-1:0] code_o
);

  // lowest index is the most urgent
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) gnt_o = N'(1) << i;
    end
  end

  assign any_o = |req_i;

  always_comb begin
    code_o = CODE_IDLE;
    for (int i = 0; i < N; i++) begin
      if (gnt_o[i]) code_o = src_code(i);
    end
  end

  // R2: at most one source granted, and only when something is requested
  always_comb begin
    a_r2_one_grant : assert ($onehot0(gnt_o));
    a_r2_grant_iff_req : assert ((gnt_o != '0) == (req_i != '0));
  end

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              ext_en,
  input  logic              ev_line,
  input  logic              rx_avail,
  input  logic              ev_rx_tmo,
  input  logic              ev_thr_empty,
  input  logic              ev_modem,
  input  logic              ev_xoff,
  input  logic              ev_xon,
  input  logic              ev_flow,
  input  logic              rd_strobe,
  output logic [STAT_W-1:0] status,
  output logic              irq
);

  logic [NSRC-1:0] set_v;
  logic [NSRC-1:0] rel_v;
  logic [NSRC-1:0] pend_v;
  logic [NSRC-1:0] vis_v;
  logic [NSRC-1:0] gnt_v;
  logic [NSRC-1:0] clr_v;
  logic            any_pend;
  logic [CODE_W-1:0] code;

  // source inputs; extended sources latch only when enabled
  always_comb begin
    set_v         = '0;
    set_v[S_LINE] = ev_line;
    set_v[S_RXD]  = rx_avail;
    set_v[S_RXTO] = ev_rx_tmo;
    set_v[S_THR]  = ev_thr_empty;
    set_v[S_MDM]  = ev_modem;
    set_v[S_XOFF] = ev_xoff & ext_en;
    set_v[S_FLOW] = ev_flow & ext_en;
    rel_v         = '0;
    rel_v[S_XOFF] = ev_xon;
  end

  assign clr_v = rd_strobe ? gnt_v : '0;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    irq_src_cell #(.KIND(src_kind(g))) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (set_v[g]),
      .rel_i    (rel_v[g]),
      .rd_clr_i (clr_v[g]),
      .pend_o   (pend_v[g])
    );
  end

  // visibility mask for the extended sources
  always_comb begin
    vis_v         = pend_v;
    vis_v[S_XOFF] = pend_v[S_XOFF] & ext_en;
    vis_v[S_FLOW] = pend_v[S_FLOW] & ext_en;
  end

  irq_prio_pick #(.N(NSRC)) u_pick (
    .req_i  (vis_v),
    .gnt_o  (gnt_v),
    .any_o  (any_pend),
    .code_o (code)
  );

  assign status = {{2{fifo_en}}, code};
  assign irq    = any_pend;

  // R4: pending flag and interrupt line are complementary
  always_comb begin
    a_r4_irq_inverse : assert (status[0] == !irq);
  end

  // R5: FIFO bits track the enable
  always_comb begin
    a_r5_fifo_bits : assert (status[7:6] == (fifo_en ? 2'b11 : 2'b00));
  end

  // R7: masked sources are never shown
  a_r7_ext_mask : assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en |-> (status[5:4] == 2'b00));

  // R6: a read of a line fault retires it unless a new fault arrives
  a_r6_line_retire : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && status[5:0] == 6'b000110 && !ev_line) |=> status[5:0] != 6'b000110);

  // R11: an event shows up as an interrupt at the next edge
  a_r11_irq_next : assert property (@(posedge clk) disable iff (!rst_n)
    (ev_line || ev_thr_empty || ev_modem || ev_rx_tmo) |=> irq);

endmodule

// File: tb/sim_uart_irq_status.sv
`timescale 1ns/1ps
module sim_uart_irq_status;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 0, ext_en = 0, ev_line = 0, rx_avail = 0, ev_rx_tmo = 0;
  logic ev_thr_empty = 0, ev_modem = 0, ev_xoff = 0, ev_xon = 0, ev_flow = 0;
  logic rd_strobe = 0;
  logic [7:0] status;
  logic irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  uart_irq_status u0 (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ext_en(ext_en),
    .ev_line(ev_line), .rx_avail(rx_avail), .ev_rx_tmo(ev_rx_tmo),
    .ev_thr_empty(ev_thr_empty), .ev_modem(ev_modem), .ev_xoff(ev_xoff),
    .ev_xon(ev_xon), .ev_flow(ev_flow), .rd_strobe(rd_strobe),
    .status(status), .irq(irq)
  );

  // reference state, built from the requirements
  bit m_line, m_rxd, m_rxto, m_thr, m_mdm, m_xoff, m_flow;

  // index of reported source: 0..6 by precedence, 7 none (R2, R7)
  function automatic int m_pick();
    if (m_line) return 0;
    if (m_rxd) return 1;
    if (m_rxto) return 2;
    if (m_thr) return 3;
    if (m_mdm) return 4;
    if (m_xoff && ext_en) return 5;
    if (m_flow && ext_en) return 6;
    return 7;
  endfunction

  function automatic logic [7:0] m_status();
    logic [5:0] c;
    case (m_pick())
      0: c = 6'b000110;
      1: c = 6'b000100;
      2: c = 6'b001100;
      3: c = 6'b000010;
      4: c = 6'b000000;
      5: c = 6'b010000;
      6: c = 6'b100000;
      default: c = 6'b000001;
    endcase
    return {fifo_en ? 2'b11 : 2'b00, c};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_line <= 0; m_rxd <= 0; m_rxto <= 0; m_thr <= 0;
      m_mdm <= 0; m_xoff <= 0; m_flow <= 0;
    end else begin
      int p;
      p = rd_strobe ? m_pick() : 7;
      m_line <= ev_line      | (m_line & (p != 0));
      m_rxd  <= rx_avail     & (p != 1);
      m_rxto <= ev_rx_tmo    | (m_rxto & (p != 2));
      m_thr  <= ev_thr_empty | (m_thr & (p != 3));
      m_mdm  <= ev_modem     | (m_mdm & (p != 4));
      m_xoff <= (ev_xoff & ext_en) | (m_xoff & !ev_xon);
      m_flow <= (ev_flow & ext_en) | (m_flow & (p != 6));
    end
  end

  task automatic chk(input string tag, input logic [7:0] exp_s);
    n_run++;
    if (status !== exp_s || irq !== !exp_s[0]) begin
      n_fail++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
               tag, status, irq, exp_s, !exp_s[0]);
    end
  endtask

  // advance one cycle: inputs change at negedge, pulses clear after one cycle
  task automatic step();
    @(negedge clk);
    ev_line = 0; ev_rx_tmo = 0; ev_thr_empty = 0; ev_modem = 0;
    ev_xoff = 0; ev_xon = 0; ev_flow = 0; rd_strobe = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2741));
    repeat (3) @(negedge clk);
    chk("R1 reset", 8'h01);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", 8'h01);

    fifo_en = 1;
    #1 chk("R5 fifo bits", 8'hC1);
    ev_thr_empty = 1;
    #1 chk("R11 before edge", 8'hC1);
    step();
    chk("R11 thr code", 8'hC2);
    ev_line = 1; step();
    chk("R2 line over thr", 8'hC6);
    rd_strobe = 1; #1 chk("R6 read value", 8'hC6);
    step();
    chk("R6 lower appears", 8'hC2);
    rd_strobe = 1; step();
    chk("R6 all retired", 8'hC1);

    ev_modem = 1; step();
    chk("R4 modem code zero", 8'hC0);
    rd_strobe = 1; ev_modem = 1; step();
    chk("R10 event during read", 8'hC0);
    rd_strobe = 1; step();
    chk("R10 then retired", 8'hC1);

    ext_en = 0; ev_flow = 1; ev_xoff = 1; step();
    chk("R7 masked", 8'hC1);
    ext_en = 1; #1 chk("R7 not latched", 8'hC1);
    ev_flow = 1; step();
    chk("R3 flow code", 8'hE0);
    rd_strobe = 1; step();
    chk("R6 flow retired", 8'hC1);

    ev_xoff = 1; step();
    chk("R8 xoff set", 8'hD0);
    rd_strobe = 1; step();
    chk("R8 read keeps xoff", 8'hD0);
    ev_xon = 1; ev_xoff = 1; step();
    chk("R8 xoff wins over xon", 8'hD0);
    ev_xon = 1; step();
    chk("R8 xon releases", 8'hC1);

    rx_avail = 1; step();
    chk("R3 rx data code", 8'hC4);
    rd_strobe = 1; step();
    chk("R9 dropped one cycle", 8'hC1);
    step();
    chk("R9 re-asserted", 8'hC4);
    ev_rx_tmo = 1; step();
    chk("R2 data over timeout", 8'hC4);
    rx_avail = 0; step();
    chk("R3 timeout code", 8'hCC);
    rd_strobe = 1; step();
    chk("R6 timeout retired", 8'hC1);

    fifo_en = 0;
    ev_line = 1; ev_rx_tmo = 1; ev_thr_empty = 1; ev_modem = 1;
    ev_xoff = 1; ev_flow = 1; step();
    chk("R2 sweep line", 8'h06);
    rd_strobe = 1; step(); chk("R2 sweep timeout", 8'h0C);
    rd_strobe = 1; step(); chk("R2 sweep thr", 8'h02);
    rd_strobe = 1; step(); chk("R2 sweep modem", 8'h00);
    rd_strobe = 1; step(); chk("R2 sweep xoff", 8'h10);
    rd_strobe = 1; step(); chk("R8 sweep xoff stays", 8'h10);
    ev_xon = 1; step(); chk("R2 sweep flow", 8'h20);
    rd_strobe = 1; step(); chk("R2 sweep empty", 8'h01);

    // random phase against the reference state
    for (int k = 0; k < 4000; k++) begin
      ev_line      = ($urandom % 16) == 0;
      ev_rx_tmo    = ($urandom % 16) == 0;
      ev_thr_empty = ($urandom % 10) == 0;
      ev_modem     = ($urandom % 16) == 0;
      ev_xoff      = ($urandom % 20) == 0;
      ev_xon       = ($urandom % 20) == 0;
      ev_flow      = ($urandom % 16) == 0;
      rd_strobe    = ($urandom % 3) == 0;
      if (($urandom % 12) == 0) rx_avail = ~rx_avail;
      if (($urandom % 50) == 0) ext_en = ~ext_en;
      if (($urandom % 40) == 0) fifo_en = ~fifo_en;
      #1 chk("R2 random", m_status());
      step();
      chk("R6 random", m_status());
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule